// File: doc/BRIEF.md
# Clock Status Change Interrupt Unit

This block watches two conditions of a chip's clock system and turns every change of either one into a latched interrupt flag. The first is the lock level of the PLL. It arrives asynchronously and is resynchronised inside the block before any edge detection. The second is a self clock mode status bit that the block itself holds.

The self clock mode status enters when a clock failure cause arrives while self clock mode is enabled. There are four causes: a failed clock quality check after power-on reset, after low-voltage reset, or on recovery from full stop, and a clock monitor failure. A loss-of-external-clock strobe also counts as a clock monitor failure when the clock monitor enable is set. The status leaves self clock mode on a quality-check pass strobe. Both entry and exit set the flag.

Software uses two byte registers. One holds the local enables. The other holds the write-one-to-clear flags and the read-only status levels. A single interrupt request line combines the enabled flags. The PLL, the clock monitor, the quality-check counter and reset generation sit outside the block and appear only as strobes and levels.

Top module: `clkstat_irq`

## Requirements
- R1: The lock flag (status register bit 0) becomes 1 on every change of the PLL lock input, rising or falling. It is visible at the port three rising clock edges after the input changes: two synchroniser stages, then the flag register. The synchronised lock level reads back in status register bit 3.
- R2: A write to the status register (address 1) clears each flag whose data bit is 1: bit 0 for lock, bit 1 for self clock mode. A 0 data bit leaves that flag unchanged.
- R3: The interrupt request is high exactly when (lock flag and lock enable) or (self clock mode flag and self clock mode interrupt enable). The enables are control register (address 0) bits 0 and 1. A cleared enable hides its flag from the request but does not stop the flag being set.
- R4: The self clock mode flag (status bit 1) becomes 1 on the same clock edge at which the self clock mode status (status bit 2) enters or leaves.
- R5: The self clock mode status changes only on an edge at which the self clock mode enable (control bit 2) is 1. Failure or pass strobes seen while it is 0 leave the status and its flag unchanged.
- R6: Each of the four failure inputs, pulsed alone for one cycle, enters self clock mode on that edge: quality-check failure after power-on reset, after low-voltage reset, or after full stop, and clock monitor failure.
- R7: The loss-of-external-clock strobe enters self clock mode only when the clock monitor enable (control bit 3) is 1. With that enable at 0 the strobe is ignored.
- R8: A quality-check pass strobe leaves self clock mode. When a failure and a pass arrive in the same cycle, the failure wins and the status is 1 afterwards.
- R9: When a hardware set and a software clear reach the same flag on the same edge, the flag is 1 afterwards.
- R10: After reset the control register, both flags, the self clock mode status and the interrupt request are all 0. Control bits 7:4 and status bits 7:4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_lock_in | input | 1 | Asynchronous PLL lock level |
| qc_fail_por | input | 1 | Strobe: quality check failed after power-on reset |
| qc_fail_lvr | input | 1 | Strobe: quality check failed after low-voltage reset |
| qc_fail_stop | input | 1 | Strobe: quality check failed on recovery from full stop |
| cmon_fail | input | 1 | Strobe: clock monitor failure |
| ext_clk_loss | input | 1 | Strobe: external clock lost; acts only with clock monitor enable |
| qc_pass | input | 1 | Strobe: quality check passed; leaves self clock mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 status/flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
A change on the PLL lock input is due in the lock flag on the third rising edge. The bench reads the flag after two edges, expecting 0, and again after the third, expecting 1, so an extra or missing synchroniser stage is caught. Strobes and register writes are driven on a falling edge and act on the next rising edge. The bench therefore reads the self clock mode status, its flag and the register contents at the following falling edge. The interrupt request is combinational from flags and enables, so it is sampled at that same falling edge.

// File: rtl/clkstat_pkg.sv
// Shared constants and types for the clock status change interrupt unit.
// Assumes a two-register map selected by a one-bit address.
package clkstat_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_FLAGS = 2;
    localparam int NUM_CAUSE = 4;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // flag indices; also their bit positions in the status register
    localparam int FLAG_LOCK = 0;
    localparam int FLAG_SCM  = 1;

    // status register level bits
    localparam int ST_SCM_ACT  = 2;
    localparam int ST_LOCK_LVL = 3;

    // control register bits (packed: first member is the MSB)
    typedef struct packed {
        logic cmon_en;  // bit 3
        logic scm_en;   // bit 2
        logic scm_ie;   // bit 1
        logic lock_ie;  // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/clkstat_sync.sv
// Multi-stage synchroniser for one asynchronous level.
// Assumes STAGES >= 2; output lags the input by STAGES edges.
module clkstat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // shift the level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkstat_w1c_flag.sv
// Sticky flag with a hardware set and a software clear.
// Assumes set has priority over clear when both arrive on one edge.
module clkstat_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // latch set events, drop on clear unless a set coincides
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/clkstat_scm_ctl.sv
// Self clock mode status holder. Enters on any failure cause,
// leaves on a quality-check pass, changes only while enabled.
// Assumes all cause inputs are single-cycle strobes in the clk domain.
module clkstat_scm_ctl #(
    parameter int NCAUSE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scm_en,
    input  logic              cmon_en,
    input  logic [NCAUSE-1:0] fail_vec,
    input  logic              ext_clk_loss,
    input  logic              qc_pass,
    output logic              active,
    output logic              changed
);
    logic any_fail;
    logic active_nxt;

    // any failure cause, with external clock loss gated by the monitor enable
    always_comb begin
        any_fail = (|fail_vec) | (ext_clk_loss & cmon_en);
    end

    // next status: failure beats pass; frozen while disabled
    always_comb begin
        active_nxt = active;
        if (scm_en) begin
            if (any_fail)     active_nxt = 1'b1;
            else if (qc_pass) active_nxt = 1'b0;
        end
    end

    assign changed = active_nxt ^ active;

    // hold the status
    always_ff @(posedge clk) begin
        if (!rst_n) active <= 1'b0;
        else        active <= active_nxt;
    end
endmodule

// File: rtl/clkstat_irq.sv
// Clock status change interrupt unit, top level.
// Watches the PLL lock level and the self clock mode status and sets a
// sticky flag on every change of either. Flags are write-one-to-clear;
// the interrupt request combines the flags with their local enables.
// Assumes the strobe inputs are synchronous to clk; pll_lock_in is not.
module clkstat_irq
    import clkstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_lock_in,
    input  logic              qc_fail_por,
    input  logic              qc_fail_lvr,
    input  logic              qc_fail_stop,
    input  logic              cmon_fail,
    input  logic              ext_clk_loss,
    input  logic              qc_pass,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    ctrl_t                ctrl_q;
    logic                 lock_sync;
    logic                 lock_prev;
    logic                 scm_active;
    logic                 scm_chg;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] flag_en;

    // control register write
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    clkstat_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pll_lock_in),
        .q     (lock_sync)
    );

    // previous synchronised lock level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) lock_prev <= 1'b0;
        else        lock_prev <= lock_sync;
    end

    clkstat_scm_ctl #(.NCAUSE(NUM_CAUSE)) u_scm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scm_en       (ctrl_q.scm_en),
        .cmon_en      (ctrl_q.cmon_en),
        .fail_vec     ({cmon_fail, qc_fail_stop, qc_fail_lvr, qc_fail_por}),
        .ext_clk_loss (ext_clk_loss),
        .qc_pass      (qc_pass),
        .active       (scm_active),
        .changed      (scm_chg)
    );

    // per-flag set, clear and enable vectors
    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_LOCK] = lock_sync ^ lock_prev;
        flag_set[FLAG_SCM]  = scm_chg;
        flag_clr = (reg_wr && reg_addr == ADDR_STAT) ? reg_wdata[NUM_FLAGS-1:0] : '0;
        flag_en            = '0;
        flag_en[FLAG_LOCK] = ctrl_q.lock_ie;
        flag_en[FLAG_SCM]  = ctrl_q.scm_ie;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        clkstat_w1c_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[g]),
            .clr   (flag_clr[g]),
            .q     (flag_q[g])
        );
    end

    // combined interrupt request
    assign irq = |(flag_q & flag_en);

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CTRL_W-1:0] = ctrl_q;
        end else begin
            reg_rdata[NUM_FLAGS-1:0] = flag_q;
            reg_rdata[ST_SCM_ACT]    = scm_active;
            reg_rdata[ST_LOCK_LVL]   = lock_sync;
        end
    end
endmodule

// File: rtl/clkstat_irq_chk.sv
// Property checker for clkstat_irq, attached by bind.
// Assumes ctrl bit layout from clkstat_pkg.
module clkstat_irq_chk
    import clkstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic [CTRL_W-1:0] ctrl,
    input logic              lock_sync,
    input logic              lock_prev,
    input logic              lock_flag,
    input logic              scm_flag,
    input logic              scm_active,
    input logic [NUM_FLAGS-1:0] clr_vec
);
    // R1: a change of the synchronised lock level sets the lock flag
    a_r1_lock_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_sync != lock_prev) |=> lock_flag);

    // R2: a clear with no coinciding change drops the lock flag
    a_r2_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[FLAG_LOCK] && lock_sync == lock_prev) |=> !lock_flag);

    // R3: the request needs at least one enabled, raised flag
    a_r3_irq_needs_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((lock_flag && ctrl[0]) || (scm_flag && ctrl[1])));

    // R4: every status transition leaves the flag raised
    a_r4_scm_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scm_active) |-> scm_flag);

    // R5: with the mode disabled the status holds
    a_r5_scm_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[2] |=> $stable(scm_active));
endmodule

bind clkstat_irq clkstat_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .ctrl       (ctrl_q),
    .lock_sync  (lock_sync),
    .lock_prev  (lock_prev),
    .lock_flag  (flag_q[0]),
    .scm_flag   (flag_q[1]),
    .scm_active (scm_active),
    .clr_vec    (flag_clr)
);

// File: tb/clkstat_irq_tb_top.sv
// Directed bench for clkstat_irq: one task per scenario.
module clkstat_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_lock_in = 1'b0;
    logic       qc_fail_por = 1'b0, qc_fail_lvr = 1'b0, qc_fail_stop = 1'b0, cmon_fail = 1'b0;
    logic       ext_clk_loss = 1'b0, qc_pass = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    clkstat_irq dut_i (
        .clk(clk), .rst_n(rst_n), .pll_lock_in(pll_lock_in),
        .qc_fail_por(qc_fail_por), .qc_fail_lvr(qc_fail_lvr),
        .qc_fail_stop(qc_fail_stop), .cmon_fail(cmon_fail),
        .ext_clk_loss(ext_clk_loss), .qc_pass(qc_pass),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one rising edge, return at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // status bit helper
    task automatic st_bit(input int b, output int v);
        logic [7:0] d;
        rd(1'b1, d);
        v = int'(d[b]);
    endtask

    task automatic pulse_cause(input int i);
        case (i)
            0: qc_fail_por  = 1'b1;
            1: qc_fail_lvr  = 1'b1;
            2: qc_fail_stop = 1'b1;
            default: cmon_fail = 1'b1;
        endcase
        step();
        qc_fail_por = 1'b0; qc_fail_lvr = 1'b0; qc_fail_stop = 1'b0; cmon_fail = 1'b0;
    endtask

    task automatic pulse_pass();
        qc_pass = 1'b1; step(); qc_pass = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d); check("R10", "ctrl after reset", d, 0);
        rd(1'b1, d); check("R10", "status after reset", d, 0);
        check("R10", "irq after reset", irq, 0);
    endtask

    task automatic t_lock_rise();
        int v;
        pll_lock_in = 1'b1;
        step(); step();
        st_bit(0, v); check("R1", "lock flag after 2 edges", v, 0);
        step();
        st_bit(0, v); check("R1", "lock flag after 3 edges", v, 1);
        st_bit(3, v); check("R1", "lock level", v, 1);
        check("R3", "irq with lock_ie=0", irq, 0);
        wr(1'b0, 8'h01);
        check("R3", "irq with lock_ie=1", irq, 1);
    endtask

    task automatic t_w1c();
        int v;
        wr(1'b1, 8'h00);
        st_bit(0, v); check("R2", "lock flag after write 0", v, 1);
        wr(1'b1, 8'h01);
        st_bit(0, v); check("R2", "lock flag after write 1", v, 0);
        check("R2", "irq after clear", irq, 0);
    endtask

    task automatic t_lock_fall();
        int v;
        pll_lock_in = 1'b0;
        step(); step();
        st_bit(0, v); check("R1", "fall flag after 2 edges", v, 0);
        step();
        st_bit(0, v); check("R1", "fall flag after 3 edges", v, 1);
        st_bit(3, v); check("R1", "lock level low", v, 0);
        wr(1'b1, 8'h01);
    endtask

    task automatic t_scm_disabled();
        int v;
        wr(1'b0, 8'h03);
        pulse_cause(0);
        pulse_cause(3);
        st_bit(2, v); check("R5", "status with scm_en=0", v, 0);
        st_bit(1, v); check("R5", "scm flag with scm_en=0", v, 0);
        check("R5", "irq with scm_en=0", irq, 0);
    endtask

    task automatic t_scm_causes();
        int v;
        wr(1'b0, 8'h07);
        for (int i = 0; i < 4; i++) begin
            pulse_cause(i);
            st_bit(2, v); check("R6", $sformatf("enter on cause %0d", i), v, 1);
            st_bit(1, v); check("R4", $sformatf("flag on entry cause %0d", i), v, 1);
            check("R3", "irq on scm entry", irq, 1);
            wr(1'b1, 8'h02);
            st_bit(1, v); check("R2", "scm flag cleared", v, 0);
            pulse_pass();
            st_bit(2, v); check("R8", "exit on pass", v, 0);
            st_bit(1, v); check("R4", "flag on exit", v, 1);
            wr(1'b1, 8'h02);
        end
    endtask

    task automatic t_ext_loss();
        int v;
        wr(1'b0, 8'h07);
        ext_clk_loss = 1'b1; step(); ext_clk_loss = 1'b0;
        st_bit(2, v); check("R7", "ext loss ignored with cmon_en=0", v, 0);
        st_bit(1, v); check("R7", "no flag with cmon_en=0", v, 0);
        wr(1'b0, 8'h0F);
        ext_clk_loss = 1'b1; step(); ext_clk_loss = 1'b0;
        st_bit(2, v); check("R7", "ext loss enters with cmon_en=1", v, 1);
        wr(1'b1, 8'h02);
        pulse_pass();
        wr(1'b1, 8'h02);
    endtask

    task automatic t_fail_vs_pass();
        int v;
        qc_fail_lvr = 1'b1; qc_pass = 1'b1;
        step();
        qc_fail_lvr = 1'b0; qc_pass = 1'b0;
        st_bit(2, v); check("R8", "failure beats pass", v, 1);
        wr(1'b1, 8'h02);
        pulse_pass();
        wr(1'b1, 8'h02);
    endtask

    task automatic t_scm_ie();
        int v;
        wr(1'b0, 8'h05);
        pulse_cause(2);
        st_bit(1, v); check("R3", "flag set with scm_ie=0", v, 1);
        check("R3", "irq hidden with scm_ie=0", irq, 0);
        wr(1'b0, 8'h07);
        check("R3", "irq shown with scm_ie=1", irq, 1);
        wr(1'b1, 8'h02);
        pulse_pass();
        wr(1'b1, 8'h02);
    endtask

    task automatic t_set_wins();
        int v;
        pulse_cause(0);
        qc_pass = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h02;
        step();
        qc_pass = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        st_bit(1, v); check("R9", "set beats clear", v, 1);
        st_bit(2, v); check("R9", "status left on pass", v, 0);
        wr(1'b1, 8'h02);
        st_bit(1, v); check("R2", "flag cleared afterwards", v, 0);
    endtask

    task automatic t_freeze();
        int v;
        pulse_cause(1);
        wr(1'b1, 8'h02);
        wr(1'b0, 8'h03);
        pulse_pass();
        st_bit(2, v); check("R5", "pass ignored with scm_en=0", v, 1);
        st_bit(1, v); check("R5", "no flag with scm_en=0", v, 0);
        wr(1'b0, 8'h07);
        pulse_pass();
        st_bit(2, v); check("R8", "pass exits once enabled", v, 0);
    endtask

    task automatic t_unused_bits();
        logic [7:0] d;
        wr(1'b0, 8'hF0);
        rd(1'b0, d); check("R10", "ctrl upper bits read 0", d, 0);
        rd(1'b1, d); check("R10", "status upper bits read 0", int'(d[7:4]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock_rise();
        t_w1c();
        t_lock_fall();
        t_scm_disabled();
        t_scm_causes();
        t_ext_loss();
        t_fail_vs_pass();
        t_scm_ie();
        t_set_wins();
        t_freeze();
        t_unused_bits();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule